// File: doc/BRIEF.md
# Reconfiguration Image Intake Engine

This block sits on the device side of a partial-reconfiguration path. A host reaches it through a 64-bit register port made of a write strobe, an address, write data and a combinational read bus. Through that port the host runs a reset request/acknowledge exchange, picks a target region and opens an operation. It then streams 32-bit image words into an internal queue and finally announces that the push is over. The engine moves queued words to the configuration logic over a valid/ready drain port. Once the queue is empty after the host's completion notice, the engine drops the start bit itself.

The host paces itself by reading a credit field, which is the number of free queue entries. Faults are kept as sticky flags that the host clears by writing back the value it read. Two input pins stand in for the configuration logic's own checks: one for a CRC failure and one for an image that does not fit the region. A 128-bit read-only interface identifier, set by parameters, lets software confirm that an image suits this static design before it programs anything.

Top module: `pr_intake_eng`

## Requirements
- R1: Registers sit at byte offsets 0x08 control, 0x10 status, 0x18 data (write-only, reads 0), 0x20 error, 0xA8 identifier high word and 0xB0 identifier low word. The identifier words read back the `IFACE_ID_HI` and `IFACE_ID_LO` parameters. Any other offset reads 0.
- R2: Writing control bit 0 = 1 makes control bit 4 (reset acknowledge) read 1 from the second clock edge after the write. While the request is held, the queue is emptied and start and complete are cleared, but the error flags keep their values. Writing bit 0 = 0 drops the acknowledge and returns the engine to idle.
- R3: Control bit 12 (start) is accepted only while the engine is idle and the same write does not set bit 0. Control bit 13 (complete) is accepted only while an operation is streaming. Otherwise both bits are ignored.
- R4: Status bits 8:0 hold the credit, which is `FIFO_DEPTH` minus the queue occupancy. It reflects a data write from the next clock edge.
- R5: Status bit 16 (busy) reads 1 while start is set or while any error flag is set, and 0 otherwise.
- R6: A write to data offset 0x18 while no operation is streaming sets error bit 3 (protocol). This includes writes while idle, in reset, or after complete. A data write while the queue is full sets error bit 4 (overflow). In both cases the word is discarded.
- R7: Error bits are sticky and clear only where a 1 is written to offset 0x20. The `crc_fail` pin sets bit 1 and the `image_bad` pin sets bit 2. When an operation ends with bit 1 or bit 2 set, bit 0 (operation failed) is also set.
- R8: After complete, the engine clears both start and complete as soon as the queue is empty, and returns to idle.
- R9: Control bits 9:7 (region) take the written value only while the engine is idle. The region is held on `drain_region` for the whole operation.
- R10: `drain_valid` is high only while an operation is open and the queue holds a word. Words leave in write order, one per cycle in which `drain_ready` is high.
- R11: Status bits 22:20 give the controller state: 0 idle, 1 reset, 2 streaming, 3 flushing. Status bits 27:24 give the host code {complete, start, reset acknowledge, reset request}, with bit 27 holding complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| crc_fail | input | 1 | Configuration logic reports a CRC failure |
| image_bad | input | 1 | Configuration logic reports an incompatible image |
| drain_valid | output | 1 | A queued word is offered downstream |
| drain_data | output | 32 | Offered image word |
| drain_ready | input | 1 | Downstream takes the offered word this cycle |
| drain_region | output | 3 | Region selected for the current operation |

## Verification
The hardest state to reach is a full queue that still receives a data write, because a well-behaved host never pushes below two credits. The bench holds `drain_ready` low, fills every entry while it reads the credit field after each word, and then pushes once more to provoke the overflow flag. A second state that is hard to reach is a reset request that lands in the middle of a stream with errors pending. The bench creates it by loading a few words and pulsing `image_bad`, then shows through the status and error registers that the queue emptied while the flag survived. Randomised streams with a toggling `drain_ready` cover ordering and release timing in between.

// File: rtl/pr_intake_pkg.sv
package pr_intake_pkg;

    localparam int ADDR_W   = 8;
    localparam int REG_W    = 64;
    localparam int WORD_W   = 32;
    localparam int CREDIT_W = 9;
    localparam int REGION_W = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_ERR   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_ID_HI = 8'hA8;
    localparam logic [ADDR_W-1:0] OFS_ID_LO = 8'hB0;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RESET  = 3'd1,
        ST_STREAM = 3'd2,
        ST_FLUSH  = 3'd3
    } eng_state_e;

    // bit 4 .. bit 0 of the error register
    typedef struct packed {
        logic fifo_ovf;
        logic push_proto;
        logic image_bad;
        logic crc_bad;
        logic op_fail;
    } err_flags_t;

    typedef struct packed {
        logic                rst_req;
        logic                rst_ack;
        logic [REGION_W-1:0] region;
        logic                start;
        logic                done;
    } ctrl_view_t;

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_view_t c);
        logic [REG_W-1:0] r;
        r      = '0;
        r[0]   = c.rst_req;
        r[4]   = c.rst_ack;
        r[9:7] = c.region;
        r[12]  = c.start;
        r[13]  = c.done;
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input logic [CREDIT_W-1:0] credit,
                                                     input logic busy,
                                                     input eng_state_e st,
                                                     input logic [3:0] host);
        logic [REG_W-1:0] r;
        r        = '0;
        r[8:0]   = credit;
        r[16]    = busy;
        r[22:20] = st;
        r[27:24] = host;
        return r;
    endfunction

endpackage

// File: rtl/pr_word_fifo.sv
module pr_word_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign pop_data = mem[rd_ptr];
    assign empty    = (count == '0);
    assign full     = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/pr_seq_ctrl.sv
module pr_seq_ctrl
    import pr_intake_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ctrl_wr,
    input  logic                wr_rst,
    input  logic                wr_start,
    input  logic                wr_done,
    input  logic [REGION_W-1:0] wr_region,
    input  logic                fifo_empty,
    output eng_state_e          state,
    output logic                rst_req,
    output logic [REGION_W-1:0] region,
    output logic                op_end
);
    eng_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:   if (ctrl_wr && wr_start && !wr_rst) nxt = ST_STREAM;
            ST_STREAM: if (ctrl_wr && wr_done)             nxt = ST_FLUSH;
            ST_FLUSH:  if (fifo_empty)                     nxt = ST_IDLE;
            ST_RESET:  if (!rst_req)                       nxt = ST_IDLE;
            default:                                       nxt = ST_IDLE;
        endcase
        if (rst_req) nxt = ST_RESET;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            rst_req <= 1'b0;
            region  <= '0;
        end else begin
            state <= nxt;
            if (ctrl_wr) rst_req <= wr_rst;
            if (ctrl_wr && state == ST_IDLE && !rst_req) region <= wr_region;
        end
    end

    assign op_end = (state == ST_FLUSH) && fifo_empty && !rst_req;

endmodule

// File: rtl/pr_err_bank.sv
module pr_err_bank
    import pr_intake_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  err_flags_t set_mask,
    input  err_flags_t clr_mask,
    output err_flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_mask) | set_mask;
        end
    end
endmodule

// File: rtl/pr_intake_eng.sv
module pr_intake_eng
    import pr_intake_pkg::*;
#(
    parameter int          FIFO_DEPTH  = 16,
    parameter logic [63:0] IFACE_ID_HI = 64'h0000_0000_0000_0000,
    parameter logic [63:0] IFACE_ID_LO = 64'h0000_0000_0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    input  logic        crc_fail,
    input  logic        image_bad,
    output logic        drain_valid,
    output logic [31:0] drain_data,
    input  logic        drain_ready,
    output logic [2:0]  drain_region
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    eng_state_e          state;
    logic                rst_req, op_end, streaming, op_open;
    logic [REGION_W-1:0] region;
    logic [CNT_W-1:0]    fifo_count;
    logic                fifo_empty, fifo_full, fifo_push, fifo_pop;
    logic [WORD_W-1:0]   fifo_head;
    logic                ctrl_wr, data_wr, err_wr;
    err_flags_t          err_set, err_clr, err_q;
    logic [CREDIT_W-1:0] credit;
    logic                busy;
    ctrl_view_t          cview;
    logic [3:0]          host_code;
    logic                wdata_unused;

    assign ctrl_wr = reg_wr && (reg_addr == OFS_CTRL);
    assign data_wr = reg_wr && (reg_addr == OFS_DATA);
    assign err_wr  = reg_wr && (reg_addr == OFS_ERR);
    assign wdata_unused = ^reg_wdata;

    pr_seq_ctrl u_seq (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (ctrl_wr),
        .wr_rst     (reg_wdata[0]),
        .wr_start   (reg_wdata[12]),
        .wr_done    (reg_wdata[13]),
        .wr_region  (reg_wdata[9:7]),
        .fifo_empty (fifo_empty),
        .state      (state),
        .rst_req    (rst_req),
        .region     (region),
        .op_end     (op_end)
    );

    assign streaming = (state == ST_STREAM);
    assign op_open   = (state == ST_STREAM) || (state == ST_FLUSH);
    assign fifo_push = data_wr && streaming && !fifo_full;
    assign drain_valid = op_open && !fifo_empty;
    assign fifo_pop    = drain_valid && drain_ready;

    pr_word_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (WORD_W),
        .CNT_W (CNT_W)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (state == ST_RESET),
        .push      (fifo_push),
        .push_data (reg_wdata[WORD_W-1:0]),
        .pop       (fifo_pop),
        .pop_data  (fifo_head),
        .count     (fifo_count),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    always_comb begin
        err_set            = '0;
        err_set.push_proto = data_wr && !streaming;
        err_set.fifo_ovf   = data_wr && streaming && fifo_full;
        err_set.crc_bad    = crc_fail;
        err_set.image_bad  = image_bad;
        err_set.op_fail    = op_end && (err_q.crc_bad || err_q.image_bad);
        err_clr            = err_wr ? err_flags_t'(reg_wdata[4:0]) : '0;
    end

    pr_err_bank u_err (
        .clk      (clk),
        .rst      (rst),
        .set_mask (err_set),
        .clr_mask (err_clr),
        .flags    (err_q)
    );

    assign credit = CREDIT_W'(FIFO_DEPTH) - CREDIT_W'(fifo_count);
    assign busy   = op_open || (|err_q);

    always_comb begin
        cview.rst_req = rst_req;
        cview.rst_ack = (state == ST_RESET);
        cview.region  = region;
        cview.start   = op_open;
        cview.done    = (state == ST_FLUSH);
        host_code     = {cview.done, cview.start, cview.rst_ack, cview.rst_req};
    end

    always_comb begin
        case (reg_addr)
            OFS_CTRL:  reg_rdata = pack_ctrl(cview);
            OFS_STAT:  reg_rdata = pack_status(credit, busy, state, host_code);
            OFS_ERR:   reg_rdata = {59'd0, err_q};
            OFS_ID_HI: reg_rdata = IFACE_ID_HI;
            OFS_ID_LO: reg_rdata = IFACE_ID_LO;
            default:   reg_rdata = '0;
        endcase
    end

    assign drain_data   = fifo_head;
    assign drain_region = region;

endmodule

// File: rtl/pr_intake_chk.sv
module pr_intake_chk
    import pr_intake_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             rst_req,
    input logic [2:0]       state,
    input logic [CNT_W-1:0] count,
    input logic             full,
    input logic             empty,
    input logic [2:0]       region,
    input logic [4:0]       errs,
    input logic             reg_wr,
    input logic [7:0]       reg_addr,
    input logic [63:0]      reg_rdata_stat,
    input logic             drain_valid
);
    logic start;
    assign start = (state == 3'd2) || (state == 3'd3);

    AST_RST_ACK: assert property (@(posedge clk) disable iff (rst)
        (rst_req && $past(rst_req)) |-> (state == 3'd1)); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        full |=> (count <= CNT_W'(DEPTH))); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == OFS_ERR) |=> (($past(errs) & ~errs) == 5'd0)); // R7

    AST_BUSY_OPEN: assert property (@(posedge clk) disable iff (rst)
        (start || errs != 5'd0) |-> reg_rdata_stat[16]); // R5

    AST_RELEASE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $fell(start) |-> ($past(empty) || $past(rst_req))); // R8

    AST_REGION_HELD: assert property (@(posedge clk) disable iff (rst)
        (start && $past(start)) |-> $stable(region)); // R9

    AST_DRAIN_OPEN: assert property (@(posedge clk) disable iff (rst)
        drain_valid |-> (start && !empty)); // R10

endmodule

bind pr_intake_eng pr_intake_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .rst_req        (rst_req),
    .state          (state),
    .count          (fifo_count),
    .full           (fifo_full),
    .empty          (fifo_empty),
    .region         (region),
    .errs           (err_q),
    .reg_wr         (reg_wr),
    .reg_addr       (reg_addr),
    .reg_rdata_stat (pack_status(credit, busy, state, host_code)),
    .drain_valid    (drain_valid)
);

// File: tb/pr_intake_eng_tb_top.sv
module pr_intake_eng_tb_top;

    localparam int          DEPTH = 16;
    localparam logic [63:0] ID_HI = 64'h5a17_c0de_0bad_f00d;
    localparam logic [63:0] ID_LO = 64'h1234_5678_9abc_def0;
    localparam logic [7:0]  A_CTRL = 8'h08, A_STAT = 8'h10, A_DATA = 8'h18,
                            A_ERR = 8'h20, A_IDH = 8'hA8, A_IDL = 8'hB0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        crc_fail = 1'b0, image_bad = 1'b0;
    logic        drain_valid, drain_ready = 1'b0;
    logic [31:0] drain_data;
    logic [2:0]  drain_region;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    logic [31:0] mdl[$];

    always #2 clk = ~clk;

    pr_intake_eng #(.FIFO_DEPTH(DEPTH), .IFACE_ID_HI(ID_HI), .IFACE_ID_LO(ID_LO)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .crc_fail(crc_fail), .image_bad(image_bad),
        .drain_valid(drain_valid), .drain_data(drain_data), .drain_ready(drain_ready),
        .drain_region(drain_region)
    );

    function automatic logic [63:0] exp_ctrl(bit rq, bit ak, int rg, bit st, bit dn);
        return 64'(rq) | (64'(ak) << 4) | (64'(rg & 7) << 7) | (64'(st) << 12) | (64'(dn) << 13);
    endfunction

    function automatic logic [63:0] exp_stat(int credit, bit busy, int code, int host);
        return 64'(credit) | (64'(busy) << 16) | (64'(code) << 20) | (64'(host) << 24);
    endfunction

    task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [63:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [63:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic set_ready(bit v);
        @(posedge clk); #1;
        drain_ready = v;
    endtask

    task automatic pulse_crc();
        @(posedge clk); #1; crc_fail = 1'b1;
        @(posedge clk); #1; crc_fail = 1'b0;
    endtask

    task automatic pulse_bad();
        @(posedge clk); #1; image_bad = 1'b1;
        @(posedge clk); #1; image_bad = 1'b0;
    endtask

    task automatic push(logic [31:0] w);
        wr(A_DATA, {32'hdead_0000, w});
        mdl.push_back(w);
    endtask

    task automatic wait_release(output logic [63:0] c);
        c = 64'h1000;
        for (int i = 0; i < 400 && c[12]; i++) rd(A_CTRL, c);
    endtask

    // R10: drain order checked against the bench queue model
    always @(negedge clk) begin
        if (!rst && drain_valid && drain_ready) begin
            tests++;
            if (mdl.size() == 0) begin
                fails++;
                $display("FAIL R10 drain with empty model: got %h expected none", drain_data);
            end else begin
                logic [31:0] e;
                e = mdl.pop_front();
                if (drain_data !== e) begin
                    fails++;
                    $display("FAIL R10 drain order: got %h expected %h", drain_data, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        int rg, n;
        void'($urandom(32'h5eed_1234));
        idle(5);
        rst = 1'b0;

        // reset state and register map
        rd(A_CTRL, v); chk("R1", "ctrl after reset", v, 64'd0);
        rd(A_STAT, v); chk("R4", "status after reset", v, exp_stat(DEPTH, 0, 0, 0));
        rd(A_IDH, v);  chk("R1", "id high", v, ID_HI);
        rd(A_IDL, v);  chk("R1", "id low", v, ID_LO);
        rd(8'h28, v);  chk("R1", "unmapped offset", v, 64'd0);
        rd(A_DATA, v); chk("R1", "data reads zero", v, 64'd0);

        // reset handshake
        wr(A_CTRL, 64'h1);
        rd(A_CTRL, v); chk("R2", "reset ack", v, exp_ctrl(1, 1, 0, 0, 0));
        rd(A_STAT, v); chk("R11", "status in reset", v, exp_stat(DEPTH, 0, 1, 4'b0011));
        wr(A_CTRL, 64'h0);
        rd(A_CTRL, v); chk("R2", "ack dropped", v, 64'd0);
        rd(A_STAT, v); chk("R11", "idle after reset", v, exp_stat(DEPTH, 0, 0, 0));

        // protocol error while idle
        wr(A_DATA, 64'h1234);
        rd(A_ERR, v);  chk("R6", "protocol flag", v, 64'h08);
        rd(A_STAT, v); chk("R5", "busy from error, credit untouched", v, exp_stat(DEPTH, 1, 0, 0));
        wr(A_ERR, 64'h08);
        rd(A_ERR, v);  chk("R7", "w1c clears", v, 64'd0);

        // start region 5, fill the queue
        wr(A_CTRL, (64'd5 << 7) | (64'd1 << 12));
        rd(A_CTRL, v); chk("R3", "start accepted", v, exp_ctrl(0, 0, 5, 1, 0));
        rd(A_STAT, v); chk("R11", "streaming status", v, exp_stat(DEPTH, 1, 2, 4'b0100));
        chk("R9", "drain region", 64'(drain_region), 64'd5);
        wr(A_CTRL, (64'd2 << 7) | (64'd1 << 12));
        rd(A_CTRL, v); chk("R9", "region held while open", v, exp_ctrl(0, 0, 5, 1, 0));
        for (int i = 0; i < DEPTH; i++) begin
            push($urandom);
            rd(A_STAT, v);
            chk("R4", "credit after push", 64'(v[8:0]), 64'(DEPTH - i - 1));
        end
        wr(A_DATA, 64'hffff_ffff);
        rd(A_ERR, v);  chk("R6", "overflow flag", v, 64'h10);
        rd(A_STAT, v); chk("R6", "overflow word dropped", 64'(v[8:0]), 64'd0);
        wr(A_ERR, 64'h10);
        set_ready(1'b1);
        for (int i = 0; i < 100 && mdl.size() != 0; i++) idle(1);
        chk("R10", "queue drained", 64'(mdl.size()), 64'd0);
        wr(A_CTRL, (64'd1 << 13));
        rd(A_CTRL, v); chk("R8", "released after complete", v, exp_ctrl(0, 0, 5, 0, 0));
        rd(A_STAT, v); chk("R5", "idle not busy", v, exp_stat(DEPTH, 0, 0, 0));

        // random streams with a toggling drain
        for (int r = 0; r < 4; r++) begin
            rg = int'($urandom % 8);
            n  = 5 + int'($urandom % 40);
            wr(A_CTRL, (64'(rg) << 7) | (64'd1 << 12));
            chk("R9", "random region", 64'(drain_region), 64'(rg));
            for (int k = 0; k < n; k++) begin
                set_ready(bit'($urandom % 2));
                rd(A_STAT, v);
                if (v[8:0] > 9'd1) push($urandom);
            end
            set_ready(1'b0);
            wr(A_CTRL, (64'd1 << 13));
            rd(A_DATA == A_DATA ? A_STAT : A_STAT, v);
            chk("R11", "flushing code", 64'(v[22:20]), 64'(v[8:0] == 9'(DEPTH) ? 0 : 3));
            wr(A_DATA, 64'h55);
            rd(A_ERR, v); chk("R6", "push after complete", v, 64'h08);
            wr(A_ERR, 64'h08);
            set_ready(1'b1);
            wait_release(v);
            chk("R8", "random release", v, exp_ctrl(0, 0, rg, 0, 0));
            chk("R10", "all words drained", 64'(mdl.size()), 64'd0);
            rd(A_STAT, v); chk("R4", "credit restored", v, exp_stat(DEPTH, 0, 0, 0));
        end

        // CRC failure marks the operation failed
        wr(A_CTRL, (64'd1 << 7) | (64'd1 << 12));
        push(32'hcafe_0001);
        push(32'hcafe_0002);
        pulse_crc();
        rd(A_ERR, v); chk("R7", "crc flag", v, 64'h02);
        wr(A_CTRL, (64'd1 << 13));
        wait_release(v);
        rd(A_ERR, v); chk("R7", "operation failed flag", v, 64'h03);
        wr(A_ERR, 64'h02);
        rd(A_ERR, v); chk("R7", "partial clear", v, 64'h01);
        rd(A_STAT, v); chk("R5", "busy while error left", v, exp_stat(DEPTH, 1, 0, 0));
        wr(A_ERR, 64'h01);
        rd(A_STAT, v); chk("R5", "busy cleared", v, exp_stat(DEPTH, 0, 0, 0));

        // ignored control bits
        wr(A_CTRL, (64'd1 << 7) | (64'd1 << 13));
        rd(A_CTRL, v); chk("R3", "complete ignored when idle", v, exp_ctrl(0, 0, 1, 0, 0));
        wr(A_CTRL, 64'h1 | (64'd1 << 12));
        rd(A_CTRL, v); chk("R3", "start ignored with reset", v, exp_ctrl(1, 1, 0, 0, 0));
        wr(A_CTRL, 64'h0);

        // reset mid-stream keeps errors
        set_ready(1'b0);
        wr(A_CTRL, (64'd3 << 7) | (64'd1 << 12));
        push(32'h0000_0aa1);
        push(32'h0000_0aa2);
        push(32'h0000_0aa3);
        pulse_bad();
        rd(A_STAT, v); chk("R4", "three queued", v, exp_stat(DEPTH - 3, 1, 2, 4'b0100));
        wr(A_CTRL, (64'd3 << 7) | 64'h1);
        idle(2);
        mdl.delete();
        rd(A_CTRL, v); chk("R2", "reset mid-stream", v, exp_ctrl(1, 1, 3, 0, 0));
        rd(A_STAT, v); chk("R2", "queue emptied in reset", v, exp_stat(DEPTH, 1, 1, 4'b0011));
        rd(A_ERR, v);  chk("R2", "errors kept in reset", v, 64'h04);
        chk("R10", "no drain in reset", 64'(drain_valid), 64'd0);
        wr(A_CTRL, 64'h0);
        rd(A_STAT, v); chk("R2", "idle after reset", v, exp_stat(DEPTH, 1, 0, 0));
        wr(A_ERR, 64'h1f);
        rd(A_ERR, v);  chk("R7", "all cleared", v, 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule